// File: doc/BRIEF.md
# Modular accumulator pointer stepper

This block keeps the 4-bit pointer that names the active accumulator. It also keeps a 3-bit mode value. When the processor reports that an arithmetic or logical operation has finished, the block can move the pointer by one, up or down.

The mode sets how many of the lowest pointer bits take part in the move. The pointer therefore wraps inside a window of 2, 4, 8 or 16 entries, and the bits above the window keep their value. Mode zero turns automatic stepping off.

Software can write the pointer directly through a load port. It can also write the mode through a load port. Both values are visible on the outputs at all times.

Top module: `acc_ptr_stepper`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, the pointer reads 0 and the mode reads 000.
- R2: With mode 000, an operation strobe leaves the pointer unchanged.
- R3: With mode 001, 010 or 011 and the direction bit at 0, a strobe adds one to the low 1, 2 or 3 pointer bits. That field wraps from its all-ones value to zero, which makes it modulo 2, 4 or 8.
- R4: Mode 100 steps the whole pointer modulo 16. Modes 101, 110 and 111 behave exactly like 100.
- R5: With the direction bit at 1, a strobe subtracts one inside the window. A window field of zero wraps to the window's all-ones value.
- R6: During a step, the pointer bits above the active window keep their value.
- R7: A pointer load takes effect at the next clock edge. It takes priority over a strobe in the same cycle.
- R8: A mode load takes effect at the next clock edge. A strobe in the same cycle steps with the mode held before that load.
- R9: With no strobe and no pointer load, the pointer keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_done | input | 1 | An arithmetic or logical operation finished this cycle |
| step_down | input | 1 | Step direction: 0 increments, 1 decrements |
| mode_we | input | 1 | Load mode_in into the mode register |
| mode_in | input | 3 | New mode value |
| ptr_we | input | 1 | Load ptr_in into the pointer |
| ptr_in | input | 4 | New pointer value |
| ptr_q | output | 4 | Current accumulator pointer |
| mode_q | output | 3 | Current mode value |

## Verification
The assertions assume that every input is a known value and is sampled at the rising edge. They place no limit on how inputs combine: every mode code is legal, reserved codes included, and any strobes may overlap.

The stimulus respects these assumptions by driving every input on the falling edge, from a seeded random source. The random values cover all eight mode codes, both directions, and overlapping pointer loads, mode loads and operation strobes. Directed cases add wraps at both ends of each window and simultaneous load and step.

// File: rtl/acc_ptr_pkg.sv
package acc_ptr_pkg;
  localparam int ACC_PTR_W  = 4;
  localparam int ACC_MODE_W = 3;

  // Where the next pointer value comes from
  typedef enum logic [1:0] {
    NXT_HOLD = 2'd0,
    NXT_LOAD = 2'd1,
    NXT_STEP = 2'd2
  } nxt_src_e;
endpackage

// File: rtl/acc_ptr_win_dec.sv
module acc_ptr_win_dec #(
  parameter int PTR_W  = 4,
  parameter int MODE_W = 3
) (
  input  logic [MODE_W-1:0] mode,
  output logic [PTR_W-1:0]  win_mask,
  output logic              step_en
);
  // A bit is inside the window when the mode code is above its index.
  // Codes at or above PTR_W therefore open the whole pointer.
  for (genvar g = 0; g < PTR_W; g++) begin : g_bit
    assign win_mask[g] = (32'(mode) > g);
  end

  assign step_en = |mode;
endmodule

// File: rtl/acc_ptr_step_unit.sv
module acc_ptr_step_unit #(
  parameter int PTR_W = 4
) (
  input  logic [PTR_W-1:0] cur,
  input  logic [PTR_W-1:0] win_mask,
  input  logic             down,
  output logic [PTR_W-1:0] nxt
);
  // Add or subtract one over the full width, then keep only the windowed
  // bits of the result. A carry or borrow past the window is dropped.
  function automatic logic [PTR_W-1:0] win_step(
    input logic [PTR_W-1:0] p,
    input logic [PTR_W-1:0] m,
    input logic             dn
  );
    logic [PTR_W-1:0] moved;
    moved = dn ? (p - PTR_W'(1)) : (p + PTR_W'(1));
    return (p & ~m) | (moved & m);
  endfunction

  assign nxt = win_step(cur, win_mask, down);
endmodule

// File: rtl/acc_ptr_stepper.sv
module acc_ptr_stepper
  import acc_ptr_pkg::*;
#(
  parameter int PTR_W  = ACC_PTR_W,
  parameter int MODE_W = ACC_MODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_done,
  input  logic              step_down,
  input  logic              mode_we,
  input  logic [MODE_W-1:0] mode_in,
  input  logic              ptr_we,
  input  logic [PTR_W-1:0]  ptr_in,
  output logic [PTR_W-1:0]  ptr_q,
  output logic [MODE_W-1:0] mode_q
);
  logic [PTR_W-1:0] win_mask;
  logic             step_en;
  logic [PTR_W-1:0] stepped_ptr;
  logic             step_fire;
  nxt_src_e         nxt_src;
  logic [PTR_W-1:0] ptr_d;

  acc_ptr_win_dec #(.PTR_W(PTR_W), .MODE_W(MODE_W)) win_dec_i (
    .mode     (mode_q),
    .win_mask (win_mask),
    .step_en  (step_en)
  );

  acc_ptr_step_unit #(.PTR_W(PTR_W)) step_unit_i (
    .cur      (ptr_q),
    .win_mask (win_mask),
    .down     (step_down),
    .nxt      (stepped_ptr)
  );

  assign step_fire = op_done & step_en & ~ptr_we;

  always_comb begin
    if (ptr_we)         nxt_src = NXT_LOAD;
    else if (step_fire) nxt_src = NXT_STEP;
    else                nxt_src = NXT_HOLD;
  end

  always_comb begin
    unique case (nxt_src)
      NXT_LOAD: ptr_d = ptr_in;
      NXT_STEP: ptr_d = stepped_ptr;
      default:  ptr_d = ptr_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      mode_q <= '0;
    end else begin
      ptr_q <= ptr_d;
      if (mode_we) mode_q <= mode_in;
    end
  end
endmodule

// File: rtl/acc_ptr_stepper_chk.sv
module acc_ptr_stepper_chk #(
  parameter int PTR_W  = 4,
  parameter int MODE_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_done,
  input logic              step_down,
  input logic              mode_we,
  input logic [MODE_W-1:0] mode_in,
  input logic              ptr_we,
  input logic [PTR_W-1:0]  ptr_in,
  input logic [PTR_W-1:0]  ptr_q,
  input logic [MODE_W-1:0] mode_q,
  input logic [PTR_W-1:0]  win_mask
);
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_we |=> ptr_q == $past(ptr_in)); // R7

  AST_MODE_ZERO_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!ptr_we && op_done && mode_q == '0) |=> $stable(ptr_q)); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ptr_we && !op_done) |=> $stable(ptr_q)); // R9

  AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (!ptr_we && op_done) |=> ((ptr_q ^ $past(ptr_q)) & ~$past(win_mask)) == '0); // R6

  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ptr_we && op_done && mode_q != '0) |=>
      (((ptr_q - $past(ptr_q)) & $past(win_mask)) ==
       (($past(step_down) ? {PTR_W{1'b1}} : PTR_W'(1)) & $past(win_mask)))); // R3

  AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    mode_we |=> mode_q == $past(mode_in)); // R8

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_we |=> $stable(mode_q)); // R8
endmodule

bind acc_ptr_stepper acc_ptr_stepper_chk #(.PTR_W(PTR_W), .MODE_W(MODE_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_done   (op_done),
  .step_down (step_down),
  .mode_we   (mode_we),
  .mode_in   (mode_in),
  .ptr_we    (ptr_we),
  .ptr_in    (ptr_in),
  .ptr_q     (ptr_q),
  .mode_q    (mode_q),
  .win_mask  (win_mask)
);

// File: tb/acc_ptr_stepper_tb_top.sv
module acc_ptr_stepper_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_done = 1'b0;
  logic       step_down = 1'b0;
  logic       mode_we = 1'b0;
  logic [2:0] mode_in = '0;
  logic       ptr_we = 1'b0;
  logic [3:0] ptr_in = '0;
  logic [3:0] ptr_q;
  logic [2:0] mode_q;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  int exp_ptr = 0;
  int exp_mode = 0;

  always #10 clk = ~clk;

  acc_ptr_stepper dut_i (
    .clk(clk), .rst_n(rst_n), .op_done(op_done), .step_down(step_down),
    .mode_we(mode_we), .mode_in(mode_in), .ptr_we(ptr_we), .ptr_in(ptr_in),
    .ptr_q(ptr_q), .mode_q(mode_q)
  );

  // Window size from the requirements: mode 0 none, 1..3 -> 2^m, >=4 -> 16
  function automatic int win_size(input int m);
    if (m == 0) return 1;
    if (m >= 4) return 16;
    return 1 << m;
  endfunction

  function automatic int model_step(input int p, input int m, input bit dn);
    int n, low, base;
    n    = win_size(m);
    low  = p % n;
    base = p - low;
    low  = dn ? (low + n - 1) % n : (low + 1) % n;
    return base + low;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // Drive one cycle of inputs at the falling edge, check after the next edge
  task automatic cycle(input bit od, input bit dn, input bit mwe, input int mv,
                       input bit pwe, input int pv);
    int old_ptr, old_mode, n;
    string tag;
    op_done = od; step_down = dn; mode_we = mwe; mode_in = 3'(mv);
    ptr_we = pwe; ptr_in = 4'(pv);
    old_ptr = exp_ptr; old_mode = exp_mode;
    @(negedge clk);
    if (pwe) exp_ptr = pv;
    else if (od && old_mode != 0) exp_ptr = model_step(old_ptr, old_mode, dn);
    if (mwe) exp_mode = mv;
    if (pwe)                     tag = "R7";
    else if (!od)                tag = "R9";
    else if (old_mode == 0)      tag = "R2";
    else if (old_mode >= 4)      tag = "R4";
    else if (dn)                 tag = "R5";
    else                         tag = "R3";
    check(int'(ptr_q) == exp_ptr, tag, int'(ptr_q), exp_ptr);
    if (!pwe && od) begin
      n = win_size(old_mode);
      check(int'(ptr_q) / n == old_ptr / n, "R6", int'(ptr_q), exp_ptr);
    end
    if (mwe) check(int'(mode_q) == exp_mode, "R8", int'(mode_q), exp_mode);
    else     check(int'(mode_q) == exp_mode, "R8 hold", int'(mode_q), exp_mode);
    op_done = 1'b0; mode_we = 1'b0; ptr_we = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    @(negedge clk);
    check(ptr_q == 4'd0, "R1 in reset ptr", int'(ptr_q), 0);
    check(mode_q == 3'd0, "R1 in reset mode", int'(mode_q), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(ptr_q == 4'd0, "R1 after reset ptr", int'(ptr_q), 0);
    check(mode_q == 3'd0, "R1 after reset mode", int'(mode_q), 0);

    // R2: mode 0 ignores strobes
    cycle(1, 0, 0, 0, 0, 0);
    cycle(1, 1, 0, 0, 0, 0);
    // R3: mode 1 wrap modulo 2 with upper bits kept (R6)
    cycle(0, 0, 1, 1, 1, 9);
    cycle(1, 0, 0, 0, 0, 0);
    cycle(1, 0, 0, 0, 0, 0);
    // R5: mode 2 decrement from 0 in window -> 3
    cycle(0, 0, 1, 2, 1, 12);
    cycle(1, 1, 0, 0, 0, 0);
    // R3: mode 3 increment from 7 wraps to 0, keeps bit 3
    cycle(0, 0, 1, 3, 1, 15);
    cycle(1, 0, 0, 0, 0, 0);
    // R4: reserved modes wrap 15 -> 0 and 0 -> 15
    for (int m = 4; m < 8; m++) begin
      cycle(0, 0, 1, m, 1, 15);
      cycle(1, 0, 0, 0, 0, 0);
      cycle(1, 1, 0, 0, 0, 0);
    end
    // R7: load beats strobe
    cycle(1, 0, 0, 0, 1, 6);
    // R8: step in a mode-load cycle uses the old mode (4 -> full wrap)
    cycle(0, 0, 1, 4, 1, 15);
    cycle(1, 0, 1, 1, 0, 0);
    cycle(1, 0, 1, 0, 0, 0);
    cycle(1, 0, 0, 0, 0, 0);

    for (int i = 0; i < 4000; i++) begin
      cycle(($urandom % 3) != 0, $urandom % 2, ($urandom % 8) == 0, $urandom % 8,
            ($urandom % 6) == 0, $urandom % 16);
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule